// File: doc/BRIEF.md
# Core-Local Timer and Software-Interrupt Unit

This block sits next to the harts of a small multi-core system. It holds a single free-running 64-bit time counter that all harts share. Each hart also gets its own 64-bit compare value and its own 32-bit software-interrupt word. From these it drives one timer-pending line and one software-pending line per hart.

Software reaches the block through a simple register bus. The bus has read and write strobes, a word address covering a 64 KiB window, 32-bit data and an access-width code. Each 64-bit value is accessed one 32-bit half at a time. Writing a half of the time counter reloads the counter, and it keeps counting from the new value. An access above the time-counter region does not complete and raises a fault that depends on the direction of the access.

Top module: `core_local_intr`

## Requirements
- R1: After reset the time counter, every compare value and every software word are zero. All software-pending lines are low and all timer-pending lines are high, because compare minus time equals zero.
- R2: A byte offset below 0x4000 selects the software word of hart (offset / 4). The hart's software-pending line is high exactly when that word is nonzero.
- R3: A byte offset from 0x4000 up to 0xBFF7 selects the compare value of hart ((offset − 0x4000) / 8). Offset bit 2 = 0 selects bits 31:0 and bit 2 = 1 selects bits 63:32. A write replaces only the selected half.
- R4: The time counter is read at offsets 0xBFF8 (bits 31:0) and 0xBFFC (bits 63:32). It advances by one on every clock edge where `tick_en` is high, and wraps from all ones to zero.
- R5: A write to either time half loads the counter with the written half joined to the unchanged other half. On the same edge this write takes priority over a tick.
- R6: The timer-pending line of hart i is high exactly when (compare_i − time), taken as a signed 64-bit value, is zero or negative.
- R7: Software and compare slots for harts at index NUM_HARTS or above read as zero. Writes to those slots change no state.
- R8: Any access at offset 0xC000 or above pulses `rd_fault` (for a read) or `wr_fault` (for a write) in the cycle after the strobe. A faulting read returns zero. An access below 0xC000 raises no fault.
- R9: `acc_w` encodes the access width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Read data is the selected word shifted right by (32 − width). Write data is shifted right by the same amount before it is stored.
- R10: `rdata` is registered. It presents the read result in the cycle after `rd_en` and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the time counter on this edge |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 14 | Byte offset bits 15:2 |
| wdata | input | 32 | Write data |
| acc_w | input | 2 | Access width code |
| rdata | output | 32 | Registered read data |
| rd_fault | output | 1 | Read access fault, one cycle after the strobe |
| wr_fault | output | 1 | Write access fault, one cycle after the strobe |
| sw_pend | output | NUM_HARTS | Software-pending line per hart |
| tmr_pend | output | NUM_HARTS | Timer-pending line per hart |

## Verification
The bench sweeps every software and compare slot of the four real harts and of two harts that do not exist. If the index decode or the bound were wrong, a pattern would land in or read back from the wrong slot.

The signed compare is driven to its edges:
- compare equal to time;
- compare one above time;
- compare one below time;
- a difference of 2^63, where an unsigned compare would give the wrong answer;
- the counter wrapping from all ones to zero.

A design that loaded the counter but let the tick win would show the write value plus one. The bench also probes the fault boundary at 0xBFFC and 0xC000. It checks both narrow widths, where a shift in the wrong direction or the wrong shift amount shows up at once as wrong data.

// File: rtl/core_local_intr.sv
module core_local_intr #(
  parameter int NUM_HARTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [15:2]          addr,
  input  logic [31:0]          wdata,
  input  logic [1:0]           acc_w,
  output logic [31:0]          rdata,
  output logic                 rd_fault,
  output logic                 wr_fault,
  output logic [NUM_HARTS-1:0] sw_pend,
  output logic [NUM_HARTS-1:0] tmr_pend
);
  localparam logic [15:2] CMP_BASE  = 14'h1000;
  localparam logic [15:2] TIME_BASE = 14'h2FFE;
  localparam logic [15:2] BAD_BASE  = 14'h3000;

  logic [31:0] sw_word [NUM_HARTS];
  logic [63:0] cmp_reg [NUM_HARTS];
  logic [63:0] mtime;

  wire in_sw   = addr < CMP_BASE;
  wire in_cmp  = (addr >= CMP_BASE) && (addr < TIME_BASE);
  wire in_time = (addr >= TIME_BASE) && (addr < BAD_BASE);
  wire bad     = addr >= BAD_BASE;
  wire hi      = addr[2];
  wire [13:0] sw_sel  = addr;
  wire [12:0] cmp_sel = addr[15:3] - 13'h0800;

  logic [4:0] sh;
  always_comb
    case (acc_w)
      2'd0:    sh = 5'd24;
      2'd1:    sh = 5'd16;
      default: sh = 5'd0;
    endcase

  wire [31:0] wval = wdata >> sh;

  logic [31:0] rword;
  always_comb begin
    rword = '0;
    if (in_time)
      rword = hi ? mtime[63:32] : mtime[31:0];
    for (int i = 0; i < NUM_HARTS; i++) begin
      if (in_sw && sw_sel == 14'(i))
        rword = sw_word[i];
      if (in_cmp && cmp_sel == 13'(i))
        rword = hi ? cmp_reg[i][63:32] : cmp_reg[i][31:0];
    end
  end

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_hart
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sw_word[g] <= '0;
        cmp_reg[g] <= '0;
      end else if (wr_en) begin
        if (in_sw && sw_sel == 14'(g))
          sw_word[g] <= wval;
        if (in_cmp && cmp_sel == 13'(g)) begin
          if (hi) cmp_reg[g][63:32] <= wval;
          else    cmp_reg[g][31:0]  <= wval;
        end
      end
    end
    wire [63:0] diff = cmp_reg[g] - mtime;
    assign tmr_pend[g] = $signed(diff) <= 64'sd0;
    assign sw_pend[g]  = |sw_word[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mtime <= '0;
    else if (wr_en && in_time)
      mtime <= hi ? {wval, mtime[31:0]} : {mtime[63:32], wval};
    else if (tick_en)
      mtime <= mtime + 64'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_fault <= 1'b0;
      wr_fault <= 1'b0;
    end else begin
      rd_fault <= rd_en && bad;
      wr_fault <= wr_en && bad;
      if (rd_en)
        rdata <= bad ? 32'd0 : (rword >> sh);
    end
  end
endmodule

module core_local_intr_chk #(
  parameter int NUM_HARTS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        rd_en,
  input logic        wr_en,
  input logic [15:2] addr,
  input logic [31:0] wdata,
  input logic [1:0]  acc_w,
  input logic [31:0] rdata,
  input logic        rd_fault,
  input logic        wr_fault,
  input logic        sw_pend0,
  input logic [63:0] mtime
);
  wire time_wr = wr_en && addr >= 14'h2FFE && addr < 14'h3000;

  assert_tick_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !time_wr) |=> mtime == $past(mtime) + 64'd1);

  assert_time_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 14'h2FFE && acc_w == 2'd2) |=> mtime[31:0] == $past(wdata));

  assert_read_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= 14'h3000) |=> (rd_fault && rdata == 32'd0));

  assert_no_spurious_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fault || wr_fault) |-> $past(addr) >= 14'h3000);

  assert_sw_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 14'h0 && acc_w == 2'd2 && wdata != 32'd0) |=> sw_pend0);

  assert_ghost_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr < 14'h1000 && addr >= 14'(NUM_HARTS)) |=> rdata == 32'd0);
endmodule

bind core_local_intr core_local_intr_chk #(.NUM_HARTS(NUM_HARTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .acc_w(acc_w), .rdata(rdata),
  .rd_fault(rd_fault), .wr_fault(wr_fault), .sw_pend0(sw_pend[0]),
  .mtime(mtime)
);

// File: tb/core_local_intr_tb.sv
module core_local_intr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] baddr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  acc_w = 2'd2;
  logic [31:0] rdata;
  logic rd_fault, wr_fault;
  logic [NH-1:0] sw_pend, tmr_pend;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_local_intr #(.NUM_HARTS(NH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_en(rd_en), .wr_en(wr_en),
    .addr(baddr[15:2]), .wdata(wdata), .acc_w(acc_w), .rdata(rdata),
    .rd_fault(rd_fault), .wr_fault(wr_fault), .sw_pend(sw_pend), .tmr_pend(tmr_pend)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [1:0] w = 2'd2);
    @(negedge clk);
    wr_en = 1'b1; baddr = a; wdata = d; acc_w = w;
    @(negedge clk);
    wr_en = 1'b0; acc_w = 2'd2;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d, input logic [1:0] w = 2'd2);
    @(negedge clk);
    rd_en = 1'b1; baddr = a; acc_w = w;
    @(negedge clk);
    rd_en = 1'b0; acc_w = 2'd2;
    d = rdata;
  endtask

  task automatic set_time(input logic [63:0] t);
    wr(16'hBFF8, t[31:0]);
    wr(16'hBFFC, t[63:32]);
  endtask

  task automatic set_cmp(input int h, input logic [63:0] c);
    wr(16'(16'h4000 + 8*h), c[31:0]);
    wr(16'(16'h4004 + 8*h), c[63:32]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1..R10 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 sw_pend", 64'(sw_pend), 64'h0);
    chk("R1 tmr_pend", 64'(tmr_pend), 64'hF);
    rd(16'hBFF8, d); chk("R1 time lo", 64'(d), 64'h0);
    rd(16'h4004, d); chk("R1 cmp0 hi", 64'(d), 64'h0);

    // R2 R3 R7 sweep over real and absent harts
    for (int h = 0; h < 6; h++) begin
      wr(16'(4*h), 32'h1000_0000 + 32'(h*17 + 1));
      wr(16'(16'h4000 + 8*h), 32'hA000_0000 + 32'(h));
      wr(16'(16'h4004 + 8*h), 32'h0000_0100 * 32'(h + 1));
    end
    for (int h = 0; h < 6; h++) begin
      rd(16'(4*h), d);
      chk(h < NH ? "R2 sw readback" : "R7 absent sw", 64'(d),
          h < NH ? 64'(32'h1000_0000 + 32'(h*17 + 1)) : 64'h0);
      rd(16'(16'h4000 + 8*h), d);
      chk(h < NH ? "R3 cmp lo" : "R7 absent cmp lo", 64'(d),
          h < NH ? 64'(32'hA000_0000 + 32'(h)) : 64'h0);
      rd(16'(16'h4004 + 8*h), d);
      chk(h < NH ? "R3 cmp hi" : "R7 absent cmp hi", 64'(d),
          h < NH ? 64'(32'h0000_0100 * 32'(h + 1)) : 64'h0);
    end
    chk("R2 all sw pending", 64'(sw_pend), 64'hF);
    chk("R6 cmp above time", 64'(tmr_pend), 64'h0);
    wr(16'h0008, 32'h0);
    chk("R2 cleared hart2", 64'(sw_pend), 64'hB);

    // R3 half write keeps other half
    wr(16'h400C, 32'hDEAD_BEEF);
    rd(16'h4008, d); chk("R3 lo kept", 64'(d), 64'hA000_0001);
    rd(16'h400C, d); chk("R3 hi replaced", 64'(d), 64'hDEAD_BEEF);

    // R4 ticking
    set_time(64'd100);
    @(negedge clk); tick_en = 1'b1;
    repeat (7) @(negedge clk);
    tick_en = 1'b0;
    rd(16'hBFF8, d); chk("R4 ticked", 64'(d), 64'd107);
    rd(16'hBFFC, d); chk("R4 hi", 64'(d), 64'd0);

    // R5 write beats tick
    @(negedge clk);
    wr_en = 1'b1; baddr = 16'hBFF8; wdata = 32'h0000_0100; tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    rd(16'hBFF8, d); chk("R5 write priority", 64'(d), 64'h100);
    set_time(64'h0000_0005_0000_0000);
    rd(16'hBFF8, d); chk("R5 combined lo", 64'(d), 64'h0);
    rd(16'hBFFC, d); chk("R5 combined hi", 64'(d), 64'h5);

    // R6 signed compare corners on hart 1
    set_cmp(1, 64'h0000_0005_0000_0000);
    chk("R6 equal", 64'(tmr_pend[1]), 64'h1);
    set_cmp(1, 64'h0000_0005_0000_0001);
    chk("R6 one above", 64'(tmr_pend[1]), 64'h0);
    set_cmp(1, 64'h0000_0004_FFFF_FFFF);
    chk("R6 one below", 64'(tmr_pend[1]), 64'h1);
    set_cmp(1, 64'h8000_0005_0000_0000);
    chk("R6 half range negative", 64'(tmr_pend[1]), 64'h1);
    set_time(64'hFFFF_FFFF_FFFF_FFFF);
    set_cmp(1, 64'h0);
    chk("R6 wrap diff one", 64'(tmr_pend[1]), 64'h0);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    chk("R4 R6 wrapped equal", 64'(tmr_pend[1]), 64'h1);
    rd(16'hBFFC, d); chk("R4 wrap hi", 64'(d), 64'h0);

    // R8 faults
    rd(16'hC000, d);
    chk("R8 rd_fault", 64'(rd_fault), 64'h1);
    chk("R8 fault data", 64'(d), 64'h0);
    rd(16'hBFFC, d);
    chk("R8 no fault at time hi", 64'(rd_fault), 64'h0);
    wr(16'hFFFC, 32'h1234);
    chk("R8 wr_fault", 64'(wr_fault), 64'h1);
    chk("R8 no rd_fault on write", 64'(rd_fault), 64'h0);

    // R9 narrow accesses
    wr(16'h0000, 32'hAB00_0000, 2'd0);
    rd(16'h0000, d); chk("R9 byte write", 64'(d), 64'hAB);
    wr(16'h0000, 32'h1234_5678);
    rd(16'h0000, d, 2'd0); chk("R9 byte read", 64'(d), 64'h12);
    rd(16'h0000, d, 2'd1); chk("R9 half read", 64'(d), 64'h1234);
    wr(16'h0004, 32'hCAFE_0000, 2'd1);
    rd(16'h0004, d); chk("R9 half write", 64'(d), 64'hCAFE);

    // R10 rdata holds without read
    hold = rdata;
    wr(16'h0000, 32'h5555_AAAA);
    repeat (3) @(negedge clk);
    chk("R10 hold", 64'(rdata), 64'(hold));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule